// File: doc/BRIEF.md
# Subword Atomic Read-Modify-Write Unit

This unit carries out one atomic read-modify-write on an 8-bit or 16-bit operand that sits inside a wider little-endian memory word. A decoded request names:

- the operation;
- the width, with byte encoded as 0 and halfword as 1;
- the byte address;
- the source operand;
- a compare value, used only by compare-and-swap;
- the acquire and release ordering flags.

The unit first checks that the address is naturally aligned. A misaligned halfword ends the request at once with a fault. An aligned request reads the containing word and works out the new lane value in a compute step. It then writes back only the byte lanes of the operand, using the write strobes. The memory port stays locked from the read to the end of the write.

The response returns the old lane value, sign-extended to the register width. The ordering flags travel unchanged alongside every memory access. The unit does not enforce ordering itself.

The controller has five named states: IDLE, READ, COMPUTE, WRITE and RESP. Its transitions are:

- **IDLE → READ**: an aligned request is accepted.
- **IDLE → RESP**: a misaligned request is accepted.
- **READ → COMPUTE**: the memory acknowledges the read.
- **COMPUTE → WRITE**: the operation needs a store.
- **COMPUTE → RESP**: a compare-and-swap mismatched, or the operation code is not recognised.
- **WRITE → RESP**: the memory acknowledges the write.
- **RESP → IDLE**: always, after one cycle.

A request is accepted only in IDLE.

Top module: `amo_sub_unit`

## Requirements
- R1: Operation codes are add 00000, swap 00001, xor 00100, compare-and-swap 00101, or 01000, and 01100. Width 0 selects a byte and width 1 selects a halfword. Swap, and, or and xor store the lane value that results from the operation.
- R2: Codes 10000, 10100, 11000 and 11100 store the lane minimum or maximum. Codes 10000 and 10100 (signed minimum and maximum) treat the operands as two's-complement values of the operand width. Codes 11000 and 11100 (unsigned minimum and maximum) treat them as zero-extended values.
- R3: The response data is the old lane value, sign-extended from bit 7 (byte) or bit 15 (halfword) to the full register width.
- R4: Source operand bits at and above the operand width have no effect on the stored value.
- R5: Compare-and-swap compares only the low operand-width bits of the compare value with the old lane. On a match it stores the source lane. On a mismatch it performs no write and still returns the old value.
- R6: A halfword request with address bit 0 set responds with the fault flag set and zero data. It makes no memory access.
- R7: In a 32-bit word, address bits [1:0] select the byte lane and bit [1] selects the halfword lane. The write strobe has one bit per byte. It is set only for the modified lanes, and all other bytes of the word keep their contents.
- R8: Add wraps modulo 2^8 or 2^16 and never carries into a neighbouring lane.
- R9: While a memory access is requested, the acquire and release outputs equal the flags of the request being served.
- R10: Responses arrive a fixed number of cycles after acceptance:
  - 5 cycles for a written request;
  - 3 cycles for a request without a write;
  - 0 cycles for a fault.

  The lock is held whenever memory is requested. The response valid is a single-cycle pulse, and a request is accepted only when the unit is idle and unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_op | input | 5 | Operation code |
| req_size | input | 1 | 0 byte, 1 halfword |
| req_addr | input | ADDR_W | Byte address |
| req_src | input | XLEN | Source operand |
| req_cmp | input | XLEN | Compare value for compare-and-swap |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_lock | output | 1 | Memory held for atomic sequence |
| mem_addr | output | ADDR_W | Word-aligned address |
| mem_wdata | output | WORD_W | Write word |
| mem_wstrb | output | WORD_W/8 | Byte write enables |
| mem_aq | output | 1 | Forwarded acquire flag |
| mem_rl | output | 1 | Forwarded release flag |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | WORD_W | Read word |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | XLEN | Sign-extended old value |
| rsp_fault | output | 1 | Misaligned fault |

## Verification
The assertions check the following properties on every cycle:

- the lock covers each memory request;
- the response valid is a one-cycle pulse;
- the forwarded ordering flags match the accepted request;
- write strobes cover exactly one byte or two bytes for the accepted width;
- a fault response is never preceded by a memory access;
- byte responses are properly sign-extended.

Only the bench's scenarios can show that the values are right. These include the arithmetic results, signed versus unsigned comparison, add wrapping, compare-and-swap matching on the narrow lane only, untouched neighbouring bytes and the exact response latency. The bench checks them against a shadow memory and reference functions.

// File: rtl/amo_sub_pkg.sv
package amo_sub_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'b00000,
        OP_SWAP = 5'b00001,
        OP_XOR  = 5'b00100,
        OP_CAS  = 5'b00101,
        OP_OR   = 5'b01000,
        OP_AND  = 5'b01100,
        OP_MIN  = 5'b10000,
        OP_MAX  = 5'b10100,
        OP_MINU = 5'b11000,
        OP_MAXU = 5'b11100
    } amo_op_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } amo_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_COMPUTE,
        ST_WRITE,
        ST_RESP
    } amo_state_e;

endpackage

// File: rtl/amo_lane_extract.sv
module amo_lane_extract #(
    parameter int WORD_W = 32,
    parameter int XLEN   = 32,
    parameter int OFS_W  = 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              half,
    output logic [15:0]       lane_z,
    output logic [XLEN-1:0]   lane_sx
);
    logic [WORD_W-1:0] shifted;

    always_comb begin
        shifted = word >> {ofs, 3'b000};
        if (half) begin
            lane_z  = shifted[15:0];
            lane_sx = {{(XLEN-16){shifted[15]}}, shifted[15:0]};
        end else begin
            lane_z  = {8'h00, shifted[7:0]};
            lane_sx = {{(XLEN-8){shifted[7]}}, shifted[7:0]};
        end
    end
endmodule

// File: rtl/amo_lane_alu.sv
module amo_lane_alu
    import amo_sub_pkg::*;
(
    input  amo_op_e     op,
    input  logic        half,
    input  logic [15:0] a,     // old lane, zero-extended
    input  logic [15:0] b,     // source lane, masked
    input  logic [15:0] c,     // compare lane, masked
    output logic [15:0] res,
    output logic        wr
);
    logic [15:0]        mask;
    logic signed [16:0] as_v, bs_v;
    logic [16:0]        au_v, bu_v;
    logic               s_lt, u_lt;
    logic [15:0]        raw;

    always_comb begin
        mask = half ? 16'hFFFF : 16'h00FF;
        as_v = half ? {a[15], a} : {{9{a[7]}}, a[7:0]};
        bs_v = half ? {b[15], b} : {{9{b[7]}}, b[7:0]};
        au_v = {1'b0, a};
        bu_v = {1'b0, b};
        s_lt = as_v < bs_v;
        u_lt = au_v < bu_v;
        wr   = 1'b1;
        unique case (op)
            OP_ADD:  raw = a + b;
            OP_SWAP: raw = b;
            OP_XOR:  raw = a ^ b;
            OP_OR:   raw = a | b;
            OP_AND:  raw = a & b;
            OP_MIN:  raw = s_lt ? a : b;
            OP_MAX:  raw = s_lt ? b : a;
            OP_MINU: raw = u_lt ? a : b;
            OP_MAXU: raw = u_lt ? b : a;
            OP_CAS: begin
                raw = b;
                wr  = ((a ^ c) & mask) == 16'h0000;
            end
            default: begin
                raw = a;
                wr  = 1'b0;
            end
        endcase
        res = raw & mask;
    end
endmodule

// File: rtl/amo_lane_merge.sv
module amo_lane_merge #(
    parameter int WORD_W = 32,
    parameter int OFS_W  = 2,
    localparam int STRB_W = WORD_W / 8
) (
    input  logic [WORD_W-1:0] word,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              half,
    input  logic [15:0]       lane,
    output logic [WORD_W-1:0] wdata,
    output logic [STRB_W-1:0] wstrb
);
    logic [WORD_W-1:0] lane_mask, ins;

    always_comb begin
        lane_mask = WORD_W'(half ? 16'hFFFF : 16'h00FF) << {ofs, 3'b000};
        ins       = WORD_W'(lane) << {ofs, 3'b000};
        wdata     = (word & ~lane_mask) | (ins & lane_mask);
        wstrb     = STRB_W'(half ? 2'b11 : 2'b01) << ofs;
    end
endmodule

// File: rtl/amo_sub_unit.sv
module amo_sub_unit
    import amo_sub_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    localparam int STRB_W = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [4:0]        req_op,
    input  logic              req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]   req_src,
    input  logic [XLEN-1:0]   req_cmp,
    input  logic              req_aq,
    input  logic              req_rl,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_wstrb,
    output logic              mem_aq,
    output logic              mem_rl,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_data,
    output logic              rsp_fault
);
    localparam int OFS_W = $clog2(STRB_W);

    amo_state_e        state_q, state_d;
    amo_op_e           op_q;
    logic              half_q, aq_q, rl_q, fault_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       src_q, cmp_q;
    logic [WORD_W-1:0] rdata_q, wdata_q;
    logic [STRB_W-1:0] strb_q;

    logic              misaligned;
    logic [15:0]       old_z, new_lane;
    logic [XLEN-1:0]   old_sx;
    logic              alu_wr;
    logic [WORD_W-1:0] merged;
    logic [STRB_W-1:0] merged_strb;

    assign misaligned = (req_size == SZ_HALF) && req_addr[0];

    amo_lane_extract #(.WORD_W(WORD_W), .XLEN(XLEN), .OFS_W(OFS_W)) u_extract (
        .word   (rdata_q),
        .ofs    (addr_q[OFS_W-1:0]),
        .half   (half_q),
        .lane_z (old_z),
        .lane_sx(old_sx)
    );

    amo_lane_alu u_alu (
        .op  (op_q),
        .half(half_q),
        .a   (old_z),
        .b   (src_q),
        .c   (cmp_q),
        .res (new_lane),
        .wr  (alu_wr)
    );

    amo_lane_merge #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_merge (
        .word (rdata_q),
        .ofs  (addr_q[OFS_W-1:0]),
        .half (half_q),
        .lane (new_lane),
        .wdata(merged),
        .wstrb(merged_strb)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = misaligned ? ST_RESP : ST_READ;
            ST_READ:    if (mem_ack)   state_d = ST_COMPUTE;
            ST_COMPUTE: state_d = alu_wr ? ST_WRITE : ST_RESP;
            ST_WRITE:   if (mem_ack)   state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Request and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_ADD;
            half_q  <= 1'b0;
            aq_q    <= 1'b0;
            rl_q    <= 1'b0;
            fault_q <= 1'b0;
            addr_q  <= '0;
            src_q   <= '0;
            cmp_q   <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
            strb_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q    <= amo_op_e'(req_op);
                half_q  <= req_size;
                aq_q    <= req_aq;
                rl_q    <= req_rl;
                fault_q <= misaligned;
                addr_q  <= req_addr;
                src_q   <= req_size ? req_src[15:0] : {8'h00, req_src[7:0]};
                cmp_q   <= req_size ? req_cmp[15:0] : {8'h00, req_cmp[7:0]};
            end
            if (state_q == ST_READ && mem_ack) rdata_q <= mem_rdata;
            if (state_q == ST_COMPUTE) begin
                wdata_q <= merged;
                strb_q  <= merged_strb;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_lock  = (state_q == ST_READ) || (state_q == ST_COMPUTE) || (state_q == ST_WRITE);
        mem_addr  = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        mem_wdata = wdata_q;
        mem_wstrb = (state_q == ST_WRITE) ? strb_q : '0;
        mem_aq    = aq_q;
        mem_rl    = rl_q;
        rsp_valid = (state_q == ST_RESP);
        rsp_fault = (state_q == ST_RESP) && fault_q;
        rsp_data  = fault_q ? '0 : old_sx;
    end
endmodule

// File: rtl/amo_sub_unit_chk.sv
module amo_sub_unit_chk #(
    parameter int XLEN   = 32,
    parameter int WORD_W = 32,
    localparam int STRB_W = WORD_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_size,
    input logic              req_aq,
    input logic              req_rl,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic [STRB_W-1:0] mem_wstrb,
    input logic              mem_aq,
    input logic              mem_rl,
    input logic              rsp_valid,
    input logic [XLEN-1:0]   rsp_data,
    input logic              rsp_fault
);
    logic seen_size, seen_aq, seen_rl, accessed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_size <= 1'b0;
            seen_aq   <= 1'b0;
            seen_rl   <= 1'b0;
            accessed  <= 1'b0;
        end else if (req_valid && req_ready) begin
            seen_size <= req_size;
            seen_aq   <= req_aq;
            seen_rl   <= req_rl;
            accessed  <= 1'b0;
        end else if (mem_req) begin
            accessed  <= 1'b1;
        end
    end

    a_r10_lock_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    a_r10_ready_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_lock && !rsp_valid));

    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_order_flags: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_aq == seen_aq && mem_rl == seen_rl));

    a_r7_byte_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !seen_size) |-> ($countones(mem_wstrb) == 1));

    a_r7_half_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && seen_size) |-> ($countones(mem_wstrb) == 2));

    a_r6_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !accessed);

    a_r3_byte_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && !seen_size) |->
            ((&rsp_data[XLEN-1:7]) || !(|rsp_data[XLEN-1:7])));
endmodule

bind amo_sub_unit amo_sub_unit_chk #(.XLEN(XLEN), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_size (req_size),
    .req_aq   (req_aq),
    .req_rl   (req_rl),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_lock (mem_lock),
    .mem_wstrb(mem_wstrb),
    .mem_aq   (mem_aq),
    .mem_rl   (mem_rl),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rsp_fault(rsp_fault)
);

// File: tb/amo_sub_unit_tb.sv
module amo_sub_unit_tb;
    localparam int XLEN = 32, ADDR_W = 32, WORD_W = 32, STRB_W = 4, DEPTH = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_size = 1'b0, req_aq = 1'b0, req_rl = 1'b0;
    logic [4:0] req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [XLEN-1:0] req_src = '0, req_cmp = '0;
    logic req_ready, mem_req, mem_we, mem_lock, mem_aq, mem_rl, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    logic [STRB_W-1:0] mem_wstrb;
    logic rsp_valid, rsp_fault;
    logic [XLEN-1:0] rsp_data;

    int n_chk = 0, n_bad = 0;
    int req_cycles = 0, ord_bad = 0;
    logic cur_aq = 1'b0, cur_rl = 1'b0;
    logic [31:0] mem [DEPTH];
    logic [31:0] shadow [DEPTH];

    always #4 clk = ~clk;

    amo_sub_unit #(.XLEN(XLEN), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dut (.*);

    function automatic logic [31:0] init_word(int i);
        return (32'(i) * 32'h01030507) ^ 32'h9E3779B9;
    endfunction

    // Memory model: acknowledge one cycle after request, write on acknowledge
    assign mem_rdata = mem[mem_addr[5:2]];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i);
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_we && mem_ack)
                for (int b = 0; b < STRB_W; b++)
                    if (mem_wstrb[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    always @(negedge clk) begin
        if (mem_req) begin
            req_cycles++;
            if (mem_aq !== cur_aq || mem_rl !== cur_rl) ord_bad++;
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_of(logic [31:0] w, logic [1:0] ofs, logic half);
        logic [31:0] s = w >> (8 * ofs);
        return half ? s[15:0] : {8'h00, s[7:0]};
    endfunction

    function automatic logic [15:0] ref_new(logic [4:0] op, logic half, logic [15:0] a,
                                            logic [15:0] b, logic [15:0] c, output logic wr);
        int sa, sb;
        logic [15:0] m = half ? 16'hFFFF : 16'h00FF;
        logic [15:0] r;
        sa = half ? int'($signed(a)) : int'($signed(a[7:0]));
        sb = half ? int'($signed(b)) : int'($signed(b[7:0]));
        wr = 1'b1;
        case (op)
            5'b00000: r = a + b;
            5'b00001: r = b;
            5'b00100: r = a ^ b;
            5'b01000: r = a | b;
            5'b01100: r = a & b;
            5'b10000: r = (sa < sb) ? a : b;
            5'b10100: r = (sa > sb) ? a : b;
            5'b11000: r = (a < b) ? a : b;
            5'b11100: r = (a > b) ? a : b;
            5'b00101: begin r = b; wr = ((a ^ c) & m) == 0; end
            default:  begin r = a; wr = 1'b0; end
        endcase
        return r & m;
    endfunction

    task automatic do_op(string req, logic [4:0] op, logic half, logic [5:0] addr,
                         logic [31:0] src, logic [31:0] cmp, logic aq, logic rl);
        logic [31:0] w, nw, exp_data;
        logic [15:0] old, nl, m;
        logic wr, bad_align;
        int lat, wd;
        int idx = int'(addr[5:2]);
        bad_align = half && addr[0];
        w   = shadow[idx];
        old = lane_of(w, addr[1:0], half);
        m   = half ? 16'hFFFF : 16'h00FF;
        nl  = ref_new(op, half, old, src[15:0] & m, cmp[15:0] & m, wr);
        exp_data = half ? {{16{old[15]}}, old} : {{24{old[7]}}, old[7:0]};
        nw = w;
        if (bad_align) begin wr = 1'b0; exp_data = '0; end
        if (wr) begin
            for (int b = 0; b < (half ? 2 : 1); b++)
                nw[8*(int'(addr[1:0]) + b) +: 8] = nl[8*b +: 8];
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_size = half; req_addr = {26'h0, addr};
        req_src = src; req_cmp = cmp; req_aq = aq; req_rl = rl;
        cur_aq = aq; cur_rl = rl; req_cycles = 0; ord_bad = 0;
        @(posedge clk);
        lat = 0; wd = 0;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            if (rsp_valid) break;
            lat++; wd++;
            if (wd > 50) break;
        end
        check({req, " response seen"}, 64'(rsp_valid), 64'd1);
        check({req, " data"}, 64'(rsp_data), 64'(exp_data));
        check({req, " fault R6"}, 64'(rsp_fault), 64'(bad_align));
        check({req, " latency R10"}, 64'(lat), 64'(bad_align ? 0 : (wr ? 5 : 3)));
        if (bad_align) check({req, " no access R6"}, 64'(req_cycles), 64'd0);
        check({req, " ordering R9"}, 64'(ord_bad), 64'd0);
        @(negedge clk);
        check({req, " memory word R7"}, 64'(mem[idx]), 64'(nw));
        shadow[idx] = nw;
    endtask

    localparam logic [4:0] OPS [10] = '{5'b00000, 5'b00001, 5'b00100, 5'b00101, 5'b01000,
                                        5'b01100, 5'b10000, 5'b10100, 5'b11000, 5'b11100};

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        for (int i = 0; i < DEPTH; i++) shadow[i] = init_word(i);
        seed_dummy = $urandom(32'h5EED_0A70);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset ready R10", 64'(req_ready), 64'd1);
        check("reset no request R10", 64'(mem_req), 64'd0);
        check("reset no response R10", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;

        // R8: byte add wraps, neighbour lane untouched
        do_op("R1 swap byte", 5'b00001, 1'b0, 6'h10, 32'h0000_00FF, 0, 0, 0);
        do_op("R8 add wrap byte", 5'b00000, 1'b0, 6'h10, 32'h0000_0001, 0, 1, 0);
        check("R8 wrapped lane", 64'(mem[4][7:0]), 64'h00);
        check("R8 neighbour", 64'(mem[4][31:8]), 64'(init_word(4) >> 8));
        do_op("R8 setup half", 5'b00001, 1'b1, 6'h16, 32'h0000_FFFF, 0, 0, 1);
        do_op("R8 add wrap half", 5'b00000, 1'b1, 6'h16, 32'h0000_0002, 0, 1, 1);
        // R2: signed vs unsigned at halfword
        do_op("R2 setup", 5'b00001, 1'b1, 6'h20, 32'h0000_8000, 0, 0, 0);
        do_op("R2 signed max", 5'b10100, 1'b1, 6'h20, 32'h0000_0001, 0, 0, 0);
        check("R2 signed max lane", 64'(mem[8][15:0]), 64'h0001);
        do_op("R2 setup2", 5'b00001, 1'b1, 6'h20, 32'h0000_8000, 0, 0, 0);
        do_op("R2 unsigned max", 5'b11100, 1'b1, 6'h20, 32'h0000_0001, 0, 0, 0);
        check("R2 unsigned max lane", 64'(mem[8][15:0]), 64'h8000);
        do_op("R2 byte signed min", 5'b10000, 1'b0, 6'h23, 32'h0000_0080, 0, 0, 0);
        do_op("R2 byte unsigned min", 5'b11000, 1'b0, 6'h22, 32'h0000_0081, 0, 0, 0);
        // R3: negative byte sign extension
        do_op("R3 setup", 5'b00001, 1'b0, 6'h05, 32'h0000_0080, 0, 0, 0);
        do_op("R3 sext byte", 5'b01000, 1'b0, 6'h05, 32'h0, 0, 0, 0);
        // R4: upper source bits ignored
        do_op("R4 swap upper ignored", 5'b00001, 1'b0, 6'h0E, 32'hABCD_EF12, 0, 0, 0);
        check("R4 lane value", 64'(mem[3][23:16]), 64'h12);
        // R5: compare-and-swap
        do_op("R5 cas mismatch", 5'b00101, 1'b0, 6'h0E, 32'h77, 32'h13, 0, 0);
        do_op("R5 cas match upper differ", 5'b00101, 1'b0, 6'h0E, 32'h77, 32'hFFFF_FF12, 0, 0);
        check("R5 cas stored", 64'(mem[3][23:16]), 64'h77);
        do_op("R5 half cas", 5'b00101, 1'b1, 6'h2A, 32'h1234, 32'hDEAD_0000 | 32'(shadow[10][31:16]), 1, 1);
        // R6: misaligned halfword
        do_op("R6 misaligned", 5'b00000, 1'b1, 6'h31, 32'h1, 0, 1, 1);
        do_op("R6 misaligned hi", 5'b00001, 1'b1, 6'h33, 32'h1, 0, 0, 1);
        // R1/R7: byte lanes at every offset
        for (int o = 0; o < 4; o++)
            do_op("R7 lane xor", 5'b00100, 1'b0, 6'(6'h24 + o), 32'h5A, 0, 0, 0);
        do_op("R1 and half", 5'b01100, 1'b1, 6'h26, 32'h0F0F, 0, 0, 0);

        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [4:0] op = OPS[$urandom_range(0, 9)];
            logic half = 1'($urandom);
            logic [5:0] a = 6'($urandom);
            logic [31:0] s = $urandom;
            logic [31:0] c = $urandom;
            if (half && $urandom_range(0, 7) != 0) a[0] = 1'b0;
            if (op == 5'b00101 && $urandom_range(0, 1) == 1)
                c = {c[31:16], lane_of(shadow[a[5:2]], a[1:0], half)} ;
            do_op("R1 random", op, half, a, s, c, 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule